// File: doc/BRIEF.md
# Light-Load Burst Controller

This block sits in the digital part of a quasi-resonant flyback controller. It decides when the converter stops normal valley-switched operation and moves into a low-power burst regime, and when it comes back. It also produces the switching pattern used during a burst. Analog comparators supply four feedback flags: below the entry level, above the burst-on level, below the burst-off level and above the exit level. The valley selector supplies its current count. A comparator on the reduced burst current limit supplies a trip flag.

To enter a burst, three things must hold together: feedback is low, the valley count is at its top value, and both have stayed that way for a whole blanking interval. Inside a burst, a hysteresis pair on the feedback starts and stops switching packets. Within a packet, a fixed-period timer turns the gate on. The gate turns off at the half-period point or on a burst current-limit trip, whichever comes first. When feedback crosses the exit level, the block leaves the burst at once. It restores the full current limit and sends a one-cycle pulse that makes the valley selector restart from its lowest count.

Top module: `lightload_burst_ctrl`

## Requirements
- R1: During and right after reset, the block is in normal operation: burst_active=0, pwm_enable=1, burst_gate=0, ilim_reduced=0, valley_clear=0.
- R2: The block enters burst (burst_active=1) after BLANK_CYCLES consecutive clock edges at which fb_below_entry=1 and valley_cnt equals VALLEY_MAX (7 by default). It changes on the last of those edges, and it can only enter from normal operation.
- R3: If fb_below_entry is 0 or valley_cnt differs from VALLEY_MAX at any edge, the blanking count restarts from zero. A full BLANK_CYCLES run is then needed again.
- R4: In the burst idle state, pwm_enable=0 and burst_gate=0.
- R5: From burst idle, fb_above_on=1 at an edge moves the block to burst switching (pwm_enable=1). From burst switching, fb_below_off=1 moves it back to burst idle.
- R6: In burst switching, a period of PERIOD_CYCLES clocks starts in the first switching cycle. burst_gate is high for the first PERIOD_CYCLES/2 cycles of each period and low for the rest.
- R7: If cs_burst_trip=1 at an edge while burst_gate is high, burst_gate is low from the next cycle until the next period starts. A trip during the low half has no effect.
- R8: fb_above_exit=1 at an edge in either burst state returns the block to normal operation on that edge. Exit takes priority over the on and off flags.
- R9: valley_clear is a single-cycle pulse. It is high in the first normal cycle after a burst exit and at no other time.
- R10: ilim_reduced is 1 exactly while burst_active is 1. This selects the reduced current limit in a burst and restores the full limit on exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_below_entry | input | 1 | Feedback below the burst entry level |
| fb_above_on | input | 1 | Feedback above the packet start level |
| fb_below_off | input | 1 | Feedback below the packet stop level |
| fb_above_exit | input | 1 | Feedback above the burst exit level |
| valley_cnt | input | VALLEY_W | Current count from the valley selector |
| cs_burst_trip | input | 1 | Sense voltage above the reduced burst limit |
| burst_active | output | 1 | Block is in either burst state |
| pwm_enable | output | 1 | Enable for the normal PWM section and packets |
| burst_gate | output | 1 | Fixed-frequency gate drive during a burst packet |
| ilim_reduced | output | 1 | Selects the reduced current limit |
| valley_clear | output | 1 | One-cycle pulse that resets the valley count to 1 |

## Verification
The bench builds the block with BLANK_CYCLES=12 and PERIOD_CYCLES=8. It keeps the default three-bit valley count with its top value of 7. This shrinks the 24 ms blanking window and the 50 kHz packet period to a few dozen cycles. A restarted blanking run, several full gate periods, a trip part-way through a period and exits from both burst states all fit into a few hundred clocks. At these sizes, the exact edge of entry, each period boundary and the single-cycle clear pulse can all be compared cycle by cycle against the reference model.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_IDLE   = 2'd1,
    ST_SWITCH = 2'd2
  } burst_state_t;

  // Gate may be high only during the first half of a packet period.
  function automatic logic in_on_half(input int unsigned phase, input int unsigned period);
    return phase < (period / 2);
  endfunction

  // Mode transition rule; exit has priority over the packet flags.
  function automatic burst_state_t next_mode(input burst_state_t cur, input logic entry_ok,
                                             input logic above_on, input logic below_off,
                                             input logic above_exit);
    burst_state_t nxt;
    nxt = cur;
    case (cur)
      ST_NORMAL: if (entry_ok) nxt = ST_IDLE;
      ST_IDLE: begin
        if (above_exit)    nxt = ST_NORMAL;
        else if (above_on) nxt = ST_SWITCH;
      end
      ST_SWITCH: begin
        if (above_exit)     nxt = ST_NORMAL;
        else if (below_off) nxt = ST_IDLE;
      end
      default: nxt = ST_NORMAL;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/burst_entry_blanker.sv
module burst_entry_blanker #(
  parameter int BLANK_CYCLES = 4800000,
  parameter int VALLEY_W     = 3,
  parameter int VALLEY_MAX   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                armed,
  input  logic                fb_low,
  input  logic [VALLEY_W-1:0] valley,
  output logic                qualified,
  output logic                entry_ok
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);

  logic [CW-1:0] run_q;

  assign qualified = armed && fb_low && (valley == VALLEY_W'(VALLEY_MAX));
  assign entry_ok  = qualified && (run_q == CW'(BLANK_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                    run_q <= '0;
    else if (!qualified || entry_ok) run_q <= '0;
    else                           run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/burst_mode_fsm.sv
module burst_mode_fsm
  import burst_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         entry_ok,
  input  logic         above_on,
  input  logic         below_off,
  input  logic         above_exit,
  output burst_state_t mode,
  output logic         exit_evt
);
  burst_state_t mode_q;

  assign mode     = mode_q;
  assign exit_evt = (mode_q != ST_NORMAL) && above_exit;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= ST_NORMAL;
    else        mode_q <= next_mode(mode_q, entry_ok, above_on, below_off, above_exit);
  end
endmodule

// File: rtl/burst_packet_gen.sv
module burst_packet_gen
  import burst_pkg::*;
#(
  parameter int PERIOD_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cs_trip,
  output logic gate,
  output logic period_start
);
  localparam int PW = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;

  logic [PW-1:0] phase_q;
  logic          trip_q;
  logic          wrap;
  logic          on_window;

  assign wrap         = (phase_q == PW'(PERIOD_CYCLES - 1));
  assign on_window    = in_on_half(32'(phase_q), PERIOD_CYCLES);
  assign gate         = run && on_window && !trip_q;
  assign period_start = run && (phase_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase_q <= '0;
      trip_q  <= 1'b0;
    end else if (wrap) begin
      phase_q <= '0;
      trip_q  <= 1'b0;
    end else begin
      phase_q <= phase_q + 1'b1;
      if (cs_trip && on_window) trip_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lightload_burst_ctrl.sv
module lightload_burst_ctrl
  import burst_pkg::*;
#(
  parameter int BLANK_CYCLES  = 4800000,
  parameter int PERIOD_CYCLES = 4000,
  parameter int VALLEY_W      = 3,
  parameter int VALLEY_MAX    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fb_below_entry,
  input  logic                fb_above_on,
  input  logic                fb_below_off,
  input  logic                fb_above_exit,
  input  logic [VALLEY_W-1:0] valley_cnt,
  input  logic                cs_burst_trip,
  output logic                burst_active,
  output logic                pwm_enable,
  output logic                burst_gate,
  output logic                ilim_reduced,
  output logic                valley_clear
);
  burst_state_t mode;
  logic         entry_ok;
  logic         entry_qualified;
  logic         exit_evt;
  logic         period_start;
  logic         clear_q;

  burst_entry_blanker #(
    .BLANK_CYCLES(BLANK_CYCLES), .VALLEY_W(VALLEY_W), .VALLEY_MAX(VALLEY_MAX)
  ) u_blank (
    .clk(clk), .rst_n(rst_n), .armed(mode == ST_NORMAL), .fb_low(fb_below_entry),
    .valley(valley_cnt), .qualified(entry_qualified), .entry_ok(entry_ok)
  );

  burst_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .entry_ok(entry_ok), .above_on(fb_above_on),
    .below_off(fb_below_off), .above_exit(fb_above_exit), .mode(mode), .exit_evt(exit_evt)
  );

  burst_packet_gen #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_pkt (
    .clk(clk), .rst_n(rst_n), .run(mode == ST_SWITCH), .cs_trip(cs_burst_trip),
    .gate(burst_gate), .period_start(period_start)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) clear_q <= 1'b0;
    else        clear_q <= exit_evt;
  end

  assign burst_active = (mode != ST_NORMAL);
  assign pwm_enable   = (mode != ST_IDLE);
  assign ilim_reduced = burst_active;
  assign valley_clear = clear_q;
endmodule

// File: rtl/lightload_burst_checker.sv
module lightload_burst_checker #(
  parameter int PERIOD_CYCLES = 4000,
  parameter int VALLEY_W      = 3,
  parameter int VALLEY_MAX    = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fb_below_entry,
  input logic                fb_above_exit,
  input logic [VALLEY_W-1:0] valley_cnt,
  input logic                cs_burst_trip,
  input logic                burst_active,
  input logic                pwm_enable,
  input logic                burst_gate,
  input logic                valley_clear,
  input logic                period_start,
  input logic                entry_qualified
);
  localparam int HALF = PERIOD_CYCLES / 2;
  localparam int HW   = $clog2(PERIOD_CYCLES + 2);

  logic [HW-1:0] high_run;
  always_ff @(posedge clk) begin
    if (!rst_n)          high_run <= '0;
    else if (burst_gate) high_run <= high_run + 1'b1;
    else                 high_run <= '0;
  end

  assert_entry_conditions_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_active) |-> ($past(fb_below_entry) && $past(valley_cnt) == VALLEY_W'(VALLEY_MAX)));

  assert_entry_only_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_active) |-> $past(entry_qualified));

  assert_idle_gate_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_enable |-> !burst_gate);

  assert_gate_starts_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_gate) |-> period_start);

  assert_duty_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_gate |-> (high_run < HW'(HALF)));

  assert_trip_ends_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_gate && cs_burst_trip) |=> !burst_gate);

  assert_exit_next_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && fb_above_exit) |=> !burst_active);

  assert_clear_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valley_clear |=> !valley_clear);

  assert_clear_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valley_clear |-> (!burst_active && $past(burst_active)));
endmodule

bind lightload_burst_ctrl lightload_burst_checker #(
  .PERIOD_CYCLES(PERIOD_CYCLES), .VALLEY_W(VALLEY_W), .VALLEY_MAX(VALLEY_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fb_below_entry(fb_below_entry), .fb_above_exit(fb_above_exit),
  .valley_cnt(valley_cnt), .cs_burst_trip(cs_burst_trip), .burst_active(burst_active),
  .pwm_enable(pwm_enable), .burst_gate(burst_gate), .valley_clear(valley_clear),
  .period_start(period_start), .entry_qualified(entry_qualified)
);

// File: tb/sim_lightload_burst_ctrl.sv
`timescale 1ns/1ps
module sim_lightload_burst_ctrl;
  localparam int BLANK  = 12;
  localparam int PERIOD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic below_entry = 0, above_on = 0, below_off = 0, above_exit = 0, cs_trip = 0;
  logic [2:0] valley = 3'd1;
  logic active, pwm_en, gate, ilim, vclr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_en = 0;

  always #2.5 clk = ~clk;

  lightload_burst_ctrl #(.BLANK_CYCLES(BLANK), .PERIOD_CYCLES(PERIOD)) u0 (
    .clk(clk), .rst_n(rst_n), .fb_below_entry(below_entry), .fb_above_on(above_on),
    .fb_below_off(below_off), .fb_above_exit(above_exit), .valley_cnt(valley),
    .cs_burst_trip(cs_trip), .burst_active(active), .pwm_enable(pwm_en),
    .burst_gate(gate), .ilim_reduced(ilim), .valley_clear(vclr)
  );

  // Behavioural reference: mode 0 normal, 1 waiting, 2 packets
  int m_mode = 0, m_run = 0, m_phase = 0;
  bit m_trip = 0, m_clr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_phase = 0; m_trip = 0; m_clr = 0;
    end else begin
      bit good, enter, leave;
      good  = below_entry && valley == 3'd7 && m_mode == 0;
      enter = good && (m_run + 1 == BLANK);
      leave = (m_mode != 0) && above_exit;
      if (m_mode == 2) begin
        if (m_phase == PERIOD - 1) begin m_phase = 0; m_trip = 0; end
        else begin
          if (cs_trip && m_phase < PERIOD / 2) m_trip = 1;
          m_phase++;
        end
      end else begin m_phase = 0; m_trip = 0; end
      m_run = (good && !enter) ? m_run + 1 : 0;
      m_clr = leave;
      if (leave) m_mode = 0;
      else if (m_mode == 0 && enter) m_mode = 1;
      else if (m_mode == 1 && above_on) m_mode = 2;
      else if (m_mode == 2 && below_off) m_mode = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n && !done) begin
      chk(active == (m_mode != 0), "R2", "burst_active", active, m_mode != 0);
      chk(pwm_en == (m_mode != 1), "R4", "pwm_enable", pwm_en, m_mode != 1);
      chk(gate == (m_mode == 2 && m_phase < PERIOD / 2 && !m_trip), "R6", "burst_gate",
          gate, m_mode == 2 && m_phase < PERIOD / 2 && !m_trip);
      chk(ilim == (m_mode != 0), "R10", "ilim_reduced", ilim, m_mode != 0);
      chk(vclr == m_clr, "R9", "valley_clear", vclr, m_clr);
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_burst();
    below_entry = 1; valley = 3'd7;
    ticks(BLANK);
    below_entry = 0; valley = 3'd3;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "WATCHDOG", "timeout", 0, 1);
    finish_run();
  end

  initial begin
    ticks(3);
    chk(!active && pwm_en && !gate && !ilim && !vclr, "R1", "reset outputs",
        {active, pwm_en, gate, ilim, vclr}, 5'b01000);
    rst_n = 1;
    ticks(1);
    chk(!active && pwm_en && !vclr, "R1", "after reset", {active, pwm_en, vclr}, 3'b010);
    cmp_en = 1;

    // R3: interrupt the blanking run with a valley count of 6
    below_entry = 1; valley = 3'd7;
    ticks(BLANK - 2);
    valley = 3'd6;
    ticks(1);
    valley = 3'd7;
    ticks(BLANK - 1);
    chk(active == 0, "R3", "no entry before restarted run completes", active, 0);
    // R2: completing a full run enters on the last edge
    ticks(1);
    chk(active == 1, "R2", "entry after full blanking run", active, 1);
    below_entry = 0; valley = 3'd3;
    ticks(2);
    chk(pwm_en == 0 && gate == 0, "R4", "idle keeps pwm off", {pwm_en, gate}, 0);

    // R5: packet start
    above_on = 1;
    ticks(1);
    above_on = 0;
    chk(pwm_en == 1 && gate == 1, "R5", "packet started, first gate high", {pwm_en, gate}, 3);
    begin
      int highs = 0;
      for (int i = 0; i < PERIOD; i++) begin
        ticks(1);
        if (gate) highs++;
      end
      chk(highs == PERIOD / 2, "R6", "gate high cycles per period", highs, PERIOD / 2);
    end

    // R7: trip at the start of a period
    while (gate) ticks(1);
    while (!gate) ticks(1);
    cs_trip = 1;
    ticks(1);
    cs_trip = 0;
    chk(gate == 0, "R7", "trip cuts gate", gate, 0);
    ticks(PERIOD - 1);
    chk(gate == 1, "R7", "gate back at next period", gate, 1);
    ticks(PERIOD / 2 + 1);
    cs_trip = 1;
    ticks(1);
    cs_trip = 0;

    // R5: packet stop
    below_off = 1;
    ticks(1);
    below_off = 0;
    chk(pwm_en == 0 && gate == 0 && active == 1, "R5", "back to idle", {active, pwm_en, gate}, 4);

    // R8/R9: exit wins over the on flag
    above_on = 1; above_exit = 1;
    ticks(1);
    above_on = 0; above_exit = 0;
    chk(active == 0 && ilim == 0, "R8", "exit from idle", {active, ilim}, 0);
    chk(vclr == 1, "R9", "clear pulse on exit", vclr, 1);
    ticks(1);
    chk(vclr == 0, "R9", "clear pulse one cycle", vclr, 0);

    // noise in normal mode has no effect
    above_on = 1; below_off = 1; cs_trip = 1;
    ticks(3);
    above_on = 0; below_off = 0; cs_trip = 0;
    chk(active == 0 && pwm_en == 1 && gate == 0, "R8", "normal unaffected by burst flags",
        {active, pwm_en, gate}, 2);

    // exit from the switching state
    enter_burst();
    chk(active == 1 && ilim == 1, "R10", "reduced limit in burst", {active, ilim}, 3);
    above_on = 1;
    ticks(1);
    above_on = 0;
    ticks(3);
    above_exit = 1; below_off = 1;
    ticks(1);
    above_exit = 0; below_off = 0;
    chk(active == 0 && gate == 0 && pwm_en == 1, "R8", "exit from switching",
        {active, gate, pwm_en}, 1);
    chk(vclr == 1, "R9", "clear after switching exit", vclr, 1);
    ticks(4);
    finish_run();
  end
endmodule